// File: doc/BRIEF.md
# Serial Flow-Control and Modem-Line Gate

This block sits between a UART and its receive and transmit buffers. It applies software (XON/XOFF) or hardware (RTS) flow control, gates the transmit stream on the modem lines, and screens received characters while the carrier is absent. Its behaviour is controlled by a 32-bit state word. A write changes that word through an AND/XOR mask pair, and the value the word held before the write is kept for reading.

On the receive side, each character from the UART is checked. It is dropped if the carrier is lost and the carrier line is being honoured. It is consumed if it is a flow-control code in XON/XOFF mode. Otherwise it is forwarded to the receive buffer. When the buffer reports that it is nearly full, the block asks the far end to pause. The request is a queued XOFF code in software mode, or a lowered RTS in hardware mode. When a removal frees enough room, the block asks the far end to resume.

On the transmit side, a queued flow-control code is offered ahead of buffered data. Buffered data is released only while CTS is asserted, no XOFF has been received, and DSR is ready or ignored.

Top module: `serial_flow_ctrl`

## Requirements
- R1: A one-cycle `st_wr` makes the state equal to ((previous state AND `st_and`) XOR `st_eor`) on every bit except 16 to 20, from the next cycle on. On the same edge `st_old` takes the previous state. Bits 16 to 20 are never changed by a write.
- R2: State bits 18, 19 and 20 show `dcd_n`, `dsr_n` and `ri` as they were one clock earlier.
- R3: With state bit 0 set, a received 0x13 sets state bit 16 and a received 0x11 clears it. Neither code is ever passed to the receive buffer. One cycle after bit 0 is seen clear, bit 16 is clear.
- R4: A buffered character is popped (`txb_pop`) only in a cycle with `tx_ready` and `cts` high, state bit 16 clear, and either `dsr_n` low or state bit 2 set. It then appears on `tx_data`.
- R5: With bit 0 set, a character passed to the buffer while `rxb_free` <= `free_thresh` sets bit 17 (if it was clear) and queues 0x13. With bit 17 set, a removal (`rxb_rd`) with `rxb_free`+1 > `free_thresh` clears bit 17 and queues 0x11. Any other removal leaves bit 17 unchanged.
- R6: A queued code is offered on `tx_data` ahead of buffered data. It is offered even while bit 16 is set, but never while `cts` is low. It leaves the queue in a cycle with `tx_ready` high.
- R7: With bit 0 clear, `rts` falls in the cycle after a character is stored under the nearly-full condition of R5. It rises after a removal that meets the release condition of R5. No code is queued and bit 17 stays clear. With bit 0 set, `rts` stays high.
- R8: With state bit 1 clear, `evt` pulses for one cycle after a low-to-high change of `dcd_n`. It also pulses after a character received while `dcd_n` is high, and that character is not stored. With bit 1 set, `dcd_n` causes neither.
- R9: `dtr` is the inverse of state bit 3.
- R10: A stored character appears on `rxb_data` with `rxb_wr` high in the cycle after `rx_valid`.
- R11: After reset, the state and `st_old` are zero, `rts` and `dtr` are high, and `evt`, `rxb_wr` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr | input | 1 | State write strobe |
| st_and | input | 32 | AND mask for a state write |
| st_eor | input | 32 | XOR mask for a state write |
| st_cur | output | 32 | Current state word |
| st_old | output | 32 | State value before the latest write |
| rx_valid | input | 1 | Character from UART receiver |
| rx_data | input | DATA_W | Received character |
| rxb_wr | output | 1 | Write strobe to receive buffer |
| rxb_data | output | DATA_W | Character to receive buffer |
| rxb_free | input | CNT_W | Free entries in receive buffer |
| free_thresh | input | CNT_W | Nearly-full threshold on free entries |
| rxb_rd | input | 1 | A character was removed from the receive buffer |
| txb_valid | input | 1 | Transmit buffer holds a character |
| txb_data | input | DATA_W | Head of transmit buffer |
| txb_pop | output | 1 | Take head of transmit buffer |
| tx_ready | input | 1 | UART transmitter accepts a character |
| tx_valid | output | 1 | Character offered to UART transmitter |
| tx_data | output | DATA_W | Character to UART transmitter |
| cts | input | 1 | Clear to send, high = clear |
| dsr_n | input | 1 | Data set ready, high = not ready |
| dcd_n | input | 1 | Carrier detect, high = carrier lost |
| ri | input | 1 | Ring indicator |
| rts | output | 1 | Request to send, high = send |
| dtr | output | 1 | Data terminal ready, high = ready |
| evt | output | 1 | One-cycle carrier event pulse |

## Verification
The bench builds the block with CNT_W = 4, so the free count and the threshold each take only 16 values. Every pairing of free count and threshold is driven through the pause and resume path, including the edges where free equals the threshold and where the free count is at its maximum. With DATA_W = 8, all 256 character codes pass through the receive path in both flow-control modes. All sixteen combinations of the four transmit-gating conditions are driven, along with a run of LFSR-generated mask pairs against an arithmetic model of the masked write.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int ST_W       = 32;
  localparam int B_XMODE    = 0;
  localparam int B_DCD_IGN  = 1;
  localparam int B_DSR_IGN  = 2;
  localparam int B_DTR_OFF  = 3;
  localparam int B_RX_STOP  = 16;
  localparam int B_HOLD     = 17;
  localparam int B_DCD      = 18;
  localparam int B_DSR      = 19;
  localparam int B_RI       = 20;
  localparam logic [ST_W-1:0] HW_BITS = 32'h001F_0000;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_CTRL = 2'd1,
    TX_DATA = 2'd2
  } tx_sel_e;
endpackage

// File: rtl/flow_rst_sync.sv
module flow_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/flow_state_reg.sv
module flow_state_reg
  import flow_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [ST_W-1:0] and_i,
  input  logic [ST_W-1:0] eor_i,
  input  logic            stop_i,
  input  logic            hold_i,
  input  logic            dcd_n_i,
  input  logic            dsr_n_i,
  input  logic            ri_i,
  output logic [ST_W-1:0] state_o,
  output logic [ST_W-1:0] old_o
);
  logic [ST_W-1:0] sw_q, sw_d;
  logic [ST_W-1:0] old_q, old_d;
  logic [2:0]      mir_q, mir_d;

  // assembled view: software bits plus hardware-owned bits
  always_comb begin
    state_o            = sw_q & ~HW_BITS;
    state_o[B_RX_STOP] = stop_i;
    state_o[B_HOLD]    = hold_i;
    state_o[B_DCD]     = mir_q[0];
    state_o[B_DSR]     = mir_q[1];
    state_o[B_RI]      = mir_q[2];
  end

  always_comb begin
    sw_d  = ((state_o & and_i) ^ eor_i) & ~HW_BITS;
    old_d = state_o;
    mir_d = {ri_i, dsr_n_i, dcd_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '0;
      old_q <= '0;
      mir_q <= '0;
    end else begin
      mir_q <= mir_d;
      if (wr_i) begin
        sw_q  <= sw_d;
        old_q <= old_d;
      end
    end
  end

  assign old_o = old_q;

  AST_STATE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((state_o & ~HW_BITS) ==
              ((($past(state_o) & $past(and_i)) ^ $past(eor_i)) & ~HW_BITS))); // R1
  AST_OLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (old_o == $past(state_o))); // R1
  AST_MIRROR_DCD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (state_o[B_DCD] == $past(dcd_n_i))); // R2
  AST_MIRROR_RI: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (state_o[B_RI] == $past(ri_i))); // R2
endmodule

// File: rtl/flow_rx_path.sv
module flow_rx_path #(
  parameter int                 DATA_W    = 8,
  parameter logic [DATA_W-1:0]  XON_CODE  = 'h11,
  parameter logic [DATA_W-1:0]  XOFF_CODE = 'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              xmode_i,
  input  logic              dcd_ign_i,
  input  logic              dcd_n_i,
  input  logic              dcd_q_i,
  output logic              rxb_wr_o,
  output logic [DATA_W-1:0] rxb_data_o,
  output logic              stop_o,
  output logic              evt_o,
  output logic              stored_o
);
  logic              lost;
  logic              is_xon, is_xoff, is_ctrl;
  logic              drop;
  logic              stop_q, stop_d;
  logic              evt_q, evt_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    lost     = !dcd_ign_i && dcd_n_i;
    is_xon   = xmode_i && (rx_data_i == XON_CODE);
    is_xoff  = xmode_i && (rx_data_i == XOFF_CODE);
    is_ctrl  = is_xon || is_xoff;
    drop     = rx_valid_i && lost;
    stored_o = rx_valid_i && !lost && !is_ctrl;
    wr_d     = stored_o;
    evt_d    = drop || (!dcd_ign_i && dcd_n_i && !dcd_q_i);
    stop_d   = stop_q;
    if (!xmode_i)                              stop_d = 1'b0;
    else if (rx_valid_i && !lost && is_xoff)   stop_d = 1'b1;
    else if (rx_valid_i && !lost && is_xon)    stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      evt_q  <= 1'b0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      stop_q <= stop_d;
      evt_q  <= evt_d;
      wr_q   <= wr_d;
      if (stored_o) data_q <= rx_data_i;
    end
  end

  assign rxb_wr_o   = wr_q;
  assign rxb_data_o = data_q;
  assign stop_o     = stop_q;
  assign evt_o      = evt_q;

  AST_XOFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && xmode_i && !lost && rx_data_i == XOFF_CODE) |=> stop_o); // R3
  AST_CTRL_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && is_ctrl) |=> !rxb_wr_o); // R3
  AST_STOP_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !xmode_i |=> !stop_o); // R3
  AST_LOST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && lost) |=> (evt_o && !rxb_wr_o)); // R8
endmodule

// File: rtl/flow_throttle.sv
module flow_throttle #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xmode_i,
  input  logic             stored_i,
  input  logic             rxb_rd_i,
  input  logic [CNT_W-1:0] rxb_free_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             taken_i,
  output logic             hold_o,
  output logic             rts_o,
  output logic             pend_vld_o,
  output logic             pend_xoff_o
);
  logic           near_full, released, throttle;
  logic [CNT_W:0] free_inc;
  logic           hold_q, hold_d;
  logic           rtsh_q, rtsh_d;
  logic           pend_q, pend_d;
  logic           xoff_q, xoff_d;

  always_comb begin
    free_inc  = {1'b0, rxb_free_i} + {{CNT_W{1'b0}}, 1'b1};
    near_full = (rxb_free_i <= thresh_i);
    released  = rxb_rd_i && (free_inc > {1'b0, thresh_i});
    throttle  = stored_i && near_full;

    hold_d = hold_q;
    rtsh_d = rtsh_q;
    pend_d = pend_q && !taken_i;
    xoff_d = xoff_q;
    if (!xmode_i) begin
      hold_d = 1'b0;
      pend_d = 1'b0;
      if (throttle)                rtsh_d = 1'b1;
      else if (released && rtsh_q) rtsh_d = 1'b0;
    end else begin
      rtsh_d = 1'b0;
      if (throttle && !hold_q) begin
        hold_d = 1'b1;
        pend_d = 1'b1;
        xoff_d = 1'b1;
      end else if (released && hold_q) begin
        hold_d = 1'b0;
        pend_d = 1'b1;
        xoff_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rtsh_q <= 1'b0;
      pend_q <= 1'b0;
      xoff_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rtsh_q <= rtsh_d;
      pend_q <= pend_d;
      xoff_q <= xoff_d;
    end
  end

  assign hold_o      = hold_q;
  assign rts_o       = !rtsh_q;
  assign pend_vld_o  = pend_q;
  assign pend_xoff_o = xoff_q;

  AST_XOFF_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (pend_vld_o && pend_xoff_o)); // R5
  AST_XON_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (xmode_i && $fell(hold_o)) |-> (pend_vld_o && !pend_xoff_o)); // R5
  AST_RTS_HIGH_XMODE: assert property (@(posedge clk) disable iff (!rst_n)
    xmode_i |=> rts_o); // R7
  AST_NO_CODE_RTS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !xmode_i |=> (!pend_vld_o && !hold_o)); // R7
endmodule

// File: rtl/flow_tx_arb.sv
module flow_tx_arb
  import flow_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] XON_CODE  = 'h11,
  parameter logic [DATA_W-1:0] XOFF_CODE = 'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_vld_i,
  input  logic              pend_xoff_i,
  input  logic              txb_valid_i,
  input  logic [DATA_W-1:0] txb_data_i,
  input  logic              cts_i,
  input  logic              dsr_n_i,
  input  logic              dsr_ign_i,
  input  logic              stop_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              txb_pop_o,
  output logic              taken_o
);
  tx_sel_e sel;
  logic    data_ok;

  always_comb begin
    data_ok = txb_valid_i && !stop_i && (dsr_ign_i || !dsr_n_i);
    if (!cts_i)          sel = TX_IDLE;
    else if (pend_vld_i) sel = TX_CTRL;
    else if (data_ok)    sel = TX_DATA;
    else                 sel = TX_IDLE;
  end

  always_comb begin
    tx_valid_o = (sel != TX_IDLE);
    txb_pop_o  = (sel == TX_DATA) && tx_ready_i;
    taken_o    = (sel == TX_CTRL) && tx_ready_i;
    case (sel)
      TX_CTRL: tx_data_o = pend_xoff_i ? XOFF_CODE : XON_CODE;
      TX_DATA: tx_data_o = txb_data_i;
      default: tx_data_o = '0;
    endcase
  end

  AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    txb_pop_o |-> (cts_i && !stop_i && (dsr_ign_i || !dsr_n_i) && tx_ready_i)); // R4
  AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld_i && cts_i) |-> (tx_valid_o && !txb_pop_o)); // R6
  AST_NO_CTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_i |-> !tx_valid_o); // R6
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(txb_pop_o && taken_o)); // R6
endmodule

// File: rtl/serial_flow_ctrl.sv
module serial_flow_ctrl
  import flow_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                CNT_W     = 6,
  parameter logic [DATA_W-1:0] XON_CODE  = 'h11,
  parameter logic [DATA_W-1:0] XOFF_CODE = 'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_wr,
  input  logic [31:0]       st_and,
  input  logic [31:0]       st_eor,
  output logic [31:0]       st_cur,
  output logic [31:0]       st_old,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rxb_wr,
  output logic [DATA_W-1:0] rxb_data,
  input  logic [CNT_W-1:0]  rxb_free,
  input  logic [CNT_W-1:0]  free_thresh,
  input  logic              rxb_rd,
  input  logic              txb_valid,
  input  logic [DATA_W-1:0] txb_data,
  output logic              txb_pop,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              cts,
  input  logic              dsr_n,
  input  logic              dcd_n,
  input  logic              ri,
  output logic              rts,
  output logic              dtr,
  output logic              evt
);
  logic rst_sn;
  logic stop, hold, stored, taken, pend_vld, pend_xoff;

  flow_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  flow_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_i    (st_wr),
    .and_i   (st_and),
    .eor_i   (st_eor),
    .stop_i  (stop),
    .hold_i  (hold),
    .dcd_n_i (dcd_n),
    .dsr_n_i (dsr_n),
    .ri_i    (ri),
    .state_o (st_cur),
    .old_o   (st_old)
  );

  flow_rx_path #(
    .DATA_W    (DATA_W),
    .XON_CODE  (XON_CODE),
    .XOFF_CODE (XOFF_CODE)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_sn),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .xmode_i    (st_cur[B_XMODE]),
    .dcd_ign_i  (st_cur[B_DCD_IGN]),
    .dcd_n_i    (dcd_n),
    .dcd_q_i    (st_cur[B_DCD]),
    .rxb_wr_o   (rxb_wr),
    .rxb_data_o (rxb_data),
    .stop_o     (stop),
    .evt_o      (evt),
    .stored_o   (stored)
  );

  flow_throttle #(
    .CNT_W (CNT_W)
  ) u_thr (
    .clk         (clk),
    .rst_n       (rst_sn),
    .xmode_i     (st_cur[B_XMODE]),
    .stored_i    (stored),
    .rxb_rd_i    (rxb_rd),
    .rxb_free_i  (rxb_free),
    .thresh_i    (free_thresh),
    .taken_i     (taken),
    .hold_o      (hold),
    .rts_o       (rts),
    .pend_vld_o  (pend_vld),
    .pend_xoff_o (pend_xoff)
  );

  flow_tx_arb #(
    .DATA_W    (DATA_W),
    .XON_CODE  (XON_CODE),
    .XOFF_CODE (XOFF_CODE)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_sn),
    .pend_vld_i  (pend_vld),
    .pend_xoff_i (pend_xoff),
    .txb_valid_i (txb_valid),
    .txb_data_i  (txb_data),
    .cts_i       (cts),
    .dsr_n_i     (dsr_n),
    .dsr_ign_i   (st_cur[B_DSR_IGN]),
    .stop_i      (stop),
    .tx_ready_i  (tx_ready),
    .tx_valid_o  (tx_valid),
    .tx_data_o   (tx_data),
    .txb_pop_o   (txb_pop),
    .taken_o     (taken)
  );

  assign dtr = !st_cur[B_DTR_OFF];

  AST_WRITE_SPARES_HW: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_wr && !rx_valid && !rxb_rd) |=> (st_cur[B_HOLD] == $past(st_cur[B_HOLD]))); // R1
endmodule

// File: tb/serial_flow_ctrl_tb_top.sv
module serial_flow_ctrl_tb_top;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [31:0] HWM = 32'h001F_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              st_wr;
  logic [31:0]       st_and, st_eor, st_cur, st_old;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_data, rxb_data, txb_data, tx_data;
  logic              rxb_wr, rxb_rd, txb_valid, txb_pop, tx_ready, tx_valid;
  logic [CNT_W-1:0]  rxb_free, free_thresh;
  logic              cts, dsr_n, dcd_n, ri, rts, dtr, evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  serial_flow_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_and(st_and), .st_eor(st_eor),
    .st_cur(st_cur), .st_old(st_old), .rx_valid(rx_valid), .rx_data(rx_data),
    .rxb_wr(rxb_wr), .rxb_data(rxb_data), .rxb_free(rxb_free),
    .free_thresh(free_thresh), .rxb_rd(rxb_rd), .txb_valid(txb_valid),
    .txb_data(txb_data), .txb_pop(txb_pop), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .cts(cts), .dsr_n(dsr_n),
    .dcd_n(dcd_n), .ri(ri), .rts(rts), .dtr(dtr), .evt(evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_state(input logic [31:0] v);
    st_wr = 1'b1; st_and = '0; st_eor = v;
    cyc();
    st_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    cyc();
    rx_valid = 1'b0;
  endtask

  task automatic drain();
    tx_ready = 1'b1;
    cyc();
    tx_ready = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h04C1_1DB7 : 32'h0);
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] m, a, e, seed, x;
    logic        stop_m;
    rst_n = 1'b0; st_wr = 0; st_and = 0; st_eor = 0; rx_valid = 0; rx_data = 0;
    rxb_free = 4'd15; free_thresh = 4'd0; rxb_rd = 0; txb_valid = 0;
    txb_data = 8'hA5; tx_ready = 0; cts = 1; dsr_n = 0; dcd_n = 0; ri = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    #1;
    // R11 reset state
    check("R11 state", st_cur, 32'h0);
    check("R11 old", st_old, 32'h0);
    check("R11 rts", {31'h0, rts}, 32'h1);
    check("R11 dtr", {31'h0, dtr}, 32'h1);
    check("R11 evt", {31'h0, evt}, 32'h0);
    check("R11 rxb_wr", {31'h0, rxb_wr}, 32'h0);
    check("R11 tx_valid", {31'h0, tx_valid}, 32'h0);

    // R1 / R9: masked writes from an LFSR
    m = 32'h0; seed = 32'h1234_5679;
    for (int i = 0; i < 64; i++) begin
      seed = lfsr(seed); a = seed;
      seed = lfsr(seed); e = seed;
      x = ((m & a) ^ e) & ~HWM;
      st_wr = 1'b1; st_and = a; st_eor = e;
      cyc();
      st_wr = 1'b0;
      #1;
      check("R1 new", st_cur, x);
      check("R1 old", st_old, m);
      check("R9 dtr", {31'h0, dtr}, {31'h0, ~x[3]});
      m = x;
    end

    // R2 mirrors
    set_state(32'h2);
    for (int k = 0; k < 8; k++) begin
      dcd_n = k[0]; dsr_n = k[1]; ri = k[2];
      cyc();
      check("R2 mirror", {29'h0, st_cur[20:18]}, k);
    end
    dcd_n = 0; dsr_n = 0; ri = 0;
    cyc();

    // R3 / R10: every code in XON/XOFF mode
    set_state(32'h1);
    stop_m = 1'b0;
    for (int d = 0; d < 256; d++) begin
      send(d[7:0]);
      if (d == 8'h13) stop_m = 1'b1;
      if (d == 8'h11) stop_m = 1'b0;
      if (d == 8'h11 || d == 8'h13)
        check("R3 consumed", {31'h0, rxb_wr}, 32'h0);
      else begin
        check("R10 stored", {31'h0, rxb_wr}, 32'h1);
        check("R10 data", {24'h0, rxb_data}, d);
      end
      check("R3 stop", {31'h0, st_cur[16]}, {31'h0, stop_m});
    end

    // R3 / R10: every code in RTS mode
    set_state(32'h0);
    for (int d = 0; d < 256; d++) begin
      send(d[7:0]);
      check("R10 stored rts", {31'h0, rxb_wr}, 32'h1);
      check("R10 data rts", {24'h0, rxb_data}, d);
      check("R3 stop off", {31'h0, st_cur[16]}, 32'h0);
    end

    // R4 transmit gating sweep
    for (int c = 0; c < 16; c++) begin
      set_state(32'h1 | (c[0] ? 32'h4 : 32'h0));
      send(c[1] ? 8'h13 : 8'h11);
      cts = c[2]; dsr_n = c[3];
      txb_valid = 1'b1; tx_ready = 1'b1;
      #1;
      check("R4 pop", {31'h0, txb_pop},
            {31'h0, c[2] & ~c[1] & (c[0] | ~c[3])});
      if (txb_pop) check("R4 data", {24'h0, tx_data}, 32'hA5);
      tx_ready = 1'b0; txb_valid = 1'b0; cts = 1'b1; dsr_n = 1'b0;
    end
    set_state(32'h1);
    send(8'h11);

    // R5 / R6 pause and resume over every free/threshold pair
    for (int t = 0; t < 16; t++) begin
      for (int f = 0; f < 16; f++) begin
        free_thresh = t[3:0]; rxb_free = f[3:0];
        send(8'h41);
        #1;
        check("R5 hold set", {31'h0, st_cur[17]}, {31'h0, f <= t});
        check("R6 offer", {31'h0, tx_valid}, {31'h0, f <= t});
        if (f <= t) begin
          check("R6 xoff code", {24'h0, tx_data}, 32'h13);
          drain();
          check("R6 dequeued", {31'h0, tx_valid}, 32'h0);
          if (t > 0) begin
            rxb_rd = 1'b1; rxb_free = t[3:0] - 4'd1;
            cyc(); rxb_rd = 1'b0; #1;
            check("R5 no release", {31'h0, st_cur[17]}, 32'h1);
            check("R5 no code", {31'h0, tx_valid}, 32'h0);
          end
          rxb_rd = 1'b1; rxb_free = t[3:0];
          cyc(); rxb_rd = 1'b0; #1;
          check("R5 release", {31'h0, st_cur[17]}, 32'h0);
          check("R5 xon code", {24'h0, tx_data}, 32'h11);
          drain();
        end
      end
    end
    rxb_free = 4'd15; free_thresh = 4'd0;

    // R6 priority of codes over data, and CTS gating of codes
    send(8'h13);
    rxb_free = 4'd0;
    send(8'h41);
    rxb_free = 4'd15;
    txb_valid = 1'b1; #1;
    check("R6 code while stopped", {23'h0, tx_valid, tx_data}, 32'h113);
    cts = 1'b0; #1;
    check("R6 cts blocks code", {31'h0, tx_valid}, 32'h0);
    cts = 1'b1;
    tx_ready = 1'b1; #1;
    check("R6 no pop with code", {31'h0, txb_pop}, 32'h0);
    cyc(); tx_ready = 1'b0; #1;
    check("R4 stopped data", {31'h0, tx_valid}, 32'h0);
    send(8'h11); #1;
    check("R4 resumed data", {23'h0, tx_valid, tx_data}, 32'h1A5);
    rxb_rd = 1'b1; cyc(); rxb_rd = 1'b0; #1;
    check("R6 xon before data", {24'h0, tx_data}, 32'h11);
    drain();
    txb_valid = 1'b0;

    // R7 RTS mode
    set_state(32'h0);
    free_thresh = 4'd5; rxb_free = 4'd5;
    send(8'h41); #1;
    check("R7 rts low", {31'h0, rts}, 32'h0);
    check("R7 no code", {31'h0, tx_valid}, 32'h0);
    check("R7 hold clear", {31'h0, st_cur[17]}, 32'h0);
    rxb_rd = 1'b1; rxb_free = 4'd4; cyc(); rxb_rd = 1'b0; #1;
    check("R7 rts still low", {31'h0, rts}, 32'h0);
    rxb_rd = 1'b1; rxb_free = 4'd5; cyc(); rxb_rd = 1'b0; #1;
    check("R7 rts high", {31'h0, rts}, 32'h1);
    rxb_free = 4'd15; free_thresh = 4'd0;

    // R8 carrier handling
    dcd_n = 1'b1; cyc();
    check("R8 rise event", {31'h0, evt}, 32'h1);
    cyc();
    check("R8 one pulse", {31'h0, evt}, 32'h0);
    send(8'h55);
    check("R8 dropped", {30'h0, rxb_wr, evt}, 32'h1);
    set_state(32'h2);
    dcd_n = 1'b0; cyc();
    dcd_n = 1'b1; cyc();
    check("R8 ignored rise", {31'h0, evt}, 32'h0);
    send(8'h56);
    check("R8 passed", {30'h0, rxb_wr, evt}, 32'h2);
    dcd_n = 1'b0; cyc();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule